// File: doc/BRIEF.md
# Configurable PCM Serial Audio Port

This block is a slave-only serial audio port that carries one channel of PCM samples in each direction. An external master supplies the bit clock and the frame sync. The port shifts a sample word out on a transmit data line and gathers a sample word from a receive data line. The core exchanges these words as 16-bit parallel values, each marked by a valid strobe.

The bit clock, frame sync and receive data are brought into the system clock domain through two-flop synchronisers. Every bit-clock edge then becomes a single-cycle event, and all framing decisions are made on these events.

A 2-bit framing field picks one of four framings: short sync pulse, long sync pulse, MSB-justified or I2S. A 2-bit word field picks 16-bit linear or 8-bit companded words. Only the word length changes with the word field; the companding arithmetic is not in this block. For the two sync-pulse framings, two control bits choose the active bit-clock edges: one sets the edge polarity, the other shifts the data by half a bit period.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, sdout_o is 0 and rx_valid_o is 0.
- R2: Framing code fmt_i selects where a frame starts and where its MSB falls. Code 0 (short sync) starts on a rising fsync_i and puts the MSB in the following bit slot. Codes 1 (long sync) and 2 (MSB-justified) start on a rising fsync_i and put the MSB in the same slot. Code 3 (I2S) starts on a falling fsync_i and puts the MSB one slot later.
- R3: The transmit word is the last word strobed in by tx_valid_i before a frame starts. A word loaded during a frame does not change that frame.
- R4: For codes 2 and 3, sdout_o changes after falling bclk_i edges and sdin_i is sampled on rising edges, whatever edge_pol_i and half_shift_i say.
- R5: For codes 0 and 1 with half_shift_i = 0: when edge_pol_i = 0, sdout_o changes after rising edges and sdin_i is sampled on falling edges. When edge_pol_i = 1, both edges swap.
- R6: For codes 0 and 1, half_shift_i = 1 moves both the transmit and the receive data by half a bit period, so each uses the other bit-clock edge.
- R7: Word code law_i 0, and the reserved code 1, select 16-bit words sent MSB first from tx_word_i[15]. Codes 2 and 3 select 8-bit words sent MSB first from tx_word_i[7]. In 8-bit mode rx_word_o[15:8] is 0.
- R8: Bit slots outside the word transmit 0, and the receive side ignores sdin_i in those slots.
- R9: rx_valid_o is a one-cycle pulse. It is high in the third system clock cycle after the bit-clock edge that captures the last word bit.
- R10: If a new frame start arrives before the last word bit is captured, the partial received word is dropped and no rx_valid_o pulse is given for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 2 | Framing code (0 short sync, 1 long sync, 2 MSB-justified, 3 I2S) |
| law_i | input | 2 | Word code (0/1 16-bit linear, 2/3 8-bit companded) |
| edge_pol_i | input | 1 | Bit-clock edge polarity for the sync-pulse framings |
| half_shift_i | input | 1 | Half-bit data shift for the sync-pulse framings |
| bclk_i | input | 1 | Bit clock from the external master |
| fsync_i | input | 1 | Frame sync from the external master |
| sdin_i | input | 1 | Serial receive data |
| sdout_o | output | 1 | Serial transmit data |
| tx_word_i | input | 16 | Next transmit word |
| tx_valid_i | input | 1 | Strobe that loads tx_word_i |
| rx_word_o | output | 16 | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe marking a new rx_word_o |

## Verification
A bit-clock edge reaches the edge detector two system cycles after it occurs. This means sdout_o settles within three cycles of a launch edge. The bench holds each bit-clock phase for eight system cycles and samples sdout_o in the last cycle of the launch phase, so the new bit has already settled and the next edge has not yet arrived. rx_valid_o is due three cycles after the capturing edge. The bench logs the cycle of that edge and checks that the strobe lands between one and six cycles later, with exactly one strobe per complete frame and none for a frame that was cut short.

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CNT_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        law_i,
  input  logic              edge_pol_i,
  input  logic              half_shift_i,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              sdin_i,
  output logic              sdout_o,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              tx_valid_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);

  localparam logic [CNT_W-1:0]  CSAT = '1;
  localparam logic [WORD_W-1:0] NMASK = {{(WORD_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [2:0] bclk_q, fs_q;
  logic [1:0] din_q;
  logic [CNT_W-1:0] tcnt, rcnt;
  logic [WORD_W-1:0] tx_hold, tx_sr, rx_sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bclk_q <= '0;
      fs_q   <= '0;
      din_q  <= '0;
    end else begin
      bclk_q <= {bclk_q[1:0], bclk_i};
      fs_q   <= {fs_q[1:0], fsync_i};
      din_q  <= {din_q[0], sdin_i};
    end

  wire b_rise   = bclk_q[1] & ~bclk_q[2];
  wire b_fall   = ~bclk_q[1] & bclk_q[2];
  wire fs_rise  = fs_q[1] & ~fs_q[2];
  wire fs_fall  = ~fs_q[1] & fs_q[2];
  wire sync_fmt = ~fmt_i[1];
  wire tx_fall  = sync_fmt ? (edge_pol_i ^ half_shift_i) : 1'b1;
  wire tx_ev    = tx_fall ? b_fall : b_rise;
  wire rx_ev    = tx_fall ? b_rise : b_fall;
  wire start    = (fmt_i == 2'd3) ? fs_fall : fs_rise;
  wire lag      = (fmt_i == 2'd0) || (fmt_i == 2'd3);
  wire narrow   = law_i[1];
  wire [CNT_W-1:0] wlen = narrow ? CNT_W'(NARROW_W) : CNT_W'(WORD_W);
  wire [CNT_W-1:0] t_nxt = (tcnt == CSAT) ? tcnt : tcnt + 1'b1;
  wire [CNT_W-1:0] r_nxt = (rcnt == CSAT) ? rcnt : rcnt + 1'b1;

  function automatic logic in_word(input logic [CNT_W-1:0] c, input logic lg,
                                   input logic [CNT_W-1:0] len);
    return (c >= CNT_W'(lg)) && ((c - CNT_W'(lg)) < len);
  endfunction

  function automatic logic pick(input logic [WORD_W-1:0] w, input logic [CNT_W-1:0] c,
                                input logic lg, input logic [CNT_W-1:0] len);
    logic b;
    logic [CNT_W-1:0] sel;
    b = 1'b0;
    sel = len - 1'b1 - (c - CNT_W'(lg));
    if (in_word(c, lg, len))
      for (int i = 0; i < WORD_W; i++)
        if (CNT_W'(i) == sel) b = w[i];
    return b;
  endfunction

  wire rx_take = rx_ev && in_word(rcnt, lag, wlen);
  wire rx_last = rx_take && ((rcnt - CNT_W'(lag)) == wlen - 1'b1);
  wire [WORD_W-1:0] rx_shift = {rx_sr[WORD_W-2:0], din_q[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_hold <= '0;
    else if (tx_valid_i) tx_hold <= tx_word_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tcnt    <= CSAT;
      tx_sr   <= '0;
      sdout_o <= 1'b0;
    end else if (start) begin
      tcnt    <= '0;
      tx_sr   <= tx_hold;
      sdout_o <= pick(tx_hold, '0, lag, wlen);
    end else if (tx_ev) begin
      tcnt    <= t_nxt;
      sdout_o <= pick(tx_sr, t_nxt, lag, wlen);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rcnt       <= CSAT;
      rx_sr      <= '0;
      rx_word_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= rx_last && !start;
      if (start) rcnt <= '0;
      else if (rx_ev) rcnt <= r_nxt;
      if (rx_take && !start) rx_sr <= rx_shift;
      if (rx_last && !start) rx_word_o <= rx_shift & (narrow ? NMASK : '1);
    end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
  a_r9_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(rx_ev));
  a_r8_sdout_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout_o) |-> $past(tx_ev || start));
  a_r3_tx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_sr) |-> $past(start));
  a_r7_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && $past(narrow)) |-> (rx_word_o[WORD_W-1:NARROW_W] == '0));

endmodule

// File: tb/pcm_serial_port_tb.sv
module pcm_serial_port_tb_top;
  localparam int CLK_NS = 10;
  localparam int HALF   = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fmt = 2'd0, law = 2'd0;
  logic pol = 1'b0, shf = 1'b0, bclk = 1'b0, fsync = 1'b0, sdin = 1'b0, tx_valid = 1'b0;
  logic [15:0] tx_word = '0;
  logic sdout, rx_valid;
  logic [15:0] rx_word;

  int nchk = 0, nfail = 0, cyc = 0, vcount = 0, vtime = 0;
  logic [15:0] vword = '0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  pcm_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .law_i(law), .edge_pol_i(pol),
    .half_shift_i(shf), .bclk_i(bclk), .fsync_i(fsync), .sdin_i(sdin),
    .sdout_o(sdout), .tx_word_i(tx_word), .tx_valid_i(tx_valid),
    .rx_word_o(rx_word), .rx_valid_o(rx_valid));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rx_valid) begin
      vcount <= vcount + 1;
      vword  <= rx_word;
      vtime  <= cyc;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int wlen(input logic [1:0] lw);
    return lw[1] ? 8 : 16;
  endfunction

  function automatic logic fs_level(input logic [1:0] fm, input int s, input int w);
    case (fm)
      2'd0: return s == 0;
      2'd1: return s < w;
      2'd2: return s < 16;
      default: return s >= 16;
    endcase
  endfunction

  task automatic load(input logic [15:0] w);
    @(negedge clk) tx_word = w; tx_valid = 1'b1;
    @(negedge clk) tx_valid = 1'b0;
  endtask

  task automatic frame(input logic [1:0] fm, input logic [1:0] lw, input logic bp,
                       input logic ms, input logic [15:0] tw, input logic [15:0] rw,
                       input int nsl, input bit midload);
    int w, lg, c0, lastc;
    logic txlvl, expb;
    bit full;
    string tg;
    w = wlen(lw);
    lg = (fm == 2'd0 || fm == 2'd3) ? 1 : 0;
    txlvl = (fm < 2) ? ~(bp ^ ms) : 1'b0;
    full = (nsl >= w + lg);
    lastc = 0;
    load(tw);
    @(negedge clk) fmt = fm; law = lw; pol = bp; shf = ms;
    bclk = ~txlvl; fsync = (fm == 2'd3);
    repeat (10) @(negedge clk);
    c0 = vcount;
    for (int s = 0; s < nsl; s++) begin
      int idx;
      idx = s - lg;
      bclk = txlvl;
      fsync = fs_level(fm, s, w);
      sdin = (idx >= 0 && idx < w) ? rw[w-1-idx] : 1'($urandom);
      if (midload && s == 3) begin
        tx_word = ~tw; tx_valid = 1'b1;
        @(negedge clk) tx_valid = 1'b0;
        repeat (HALF-2) @(negedge clk);
      end else
        repeat (HALF-1) @(negedge clk);
      expb = (idx >= 0 && idx < w) ? tw[w-1-idx] : 1'b0;
      if (!(idx >= 0 && idx < w)) tg = "R8 pad slot";
      else if (midload) tg = "R3 word latch";
      else if (fm >= 2) tg = "R4 fixed edges";
      else if (ms) tg = "R6 half shift";
      else tg = "R5 sync edges";
      chk(tg, 16'(sdout), 16'(expb));
      @(negedge clk) bclk = ~txlvl;
      if (idx == w - 1) lastc = cyc;
      repeat (HALF-1) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    if (full) begin
      chk("R9 one strobe", 16'(vcount - c0), 16'd1);
      chk(lw[1] ? "R7 narrow word" : "R2 framing rx word", vword,
          lw[1] ? {8'h00, rw[7:0]} : rw);
      chk("R9 strobe latency", 16'((vtime - lastc >= 1 && vtime - lastc <= 6) ? 1 : 0), 16'd1);
    end else
      chk("R10 dropped partial", 16'(vcount - c0), 16'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset sdout", 16'(sdout), 16'd0);
    chk("R1 reset valid", 16'(rx_valid), 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle sdout", 16'(sdout), 16'd0);
    frame(2'd0, 2'd0, 1'b0, 1'b0, 16'hA53C, 16'h3CA5, 32, 0);
    frame(2'd1, 2'd0, 1'b0, 1'b0, 16'h8001, 16'h7FFE, 16, 0);
    frame(2'd2, 2'd0, 1'b0, 1'b0, 16'hF00F, 16'h0FF0, 32, 0);
    frame(2'd3, 2'd0, 1'b0, 1'b0, 16'h1234, 16'hFEDC, 32, 0);
    frame(2'd0, 2'd0, 1'b1, 1'b0, 16'hC3C3, 16'h5A5A, 32, 0);
    frame(2'd1, 2'd0, 1'b0, 1'b1, 16'h6996, 16'h9669, 16, 0);
    frame(2'd0, 2'd0, 1'b1, 1'b1, 16'hBEEF, 16'hDEAD, 32, 0);
    frame(2'd2, 2'd0, 1'b1, 1'b1, 16'h0F1E, 16'hE1F0, 32, 0);
    frame(2'd3, 2'd0, 1'b1, 1'b0, 16'h55AA, 16'hAA55, 32, 0);
    frame(2'd1, 2'd1, 1'b0, 1'b0, 16'h8F01, 16'h10F8, 16, 0);
    frame(2'd1, 2'd2, 1'b0, 1'b0, 16'hFF81, 16'hFFC3, 16, 0);
    frame(2'd3, 2'd3, 1'b0, 1'b0, 16'h00E7, 16'h1218, 32, 0);
    frame(2'd0, 2'd2, 1'b1, 1'b0, 16'h7701, 16'h33A6, 32, 0);
    frame(2'd2, 2'd0, 1'b0, 1'b0, 16'h4C4C, 16'h2B2B, 32, 1);
    frame(2'd1, 2'd0, 1'b0, 1'b0, 16'h9999, 16'h6666, 6, 0);
    frame(2'd1, 2'd0, 1'b0, 1'b0, 16'h1357, 16'h2468, 16, 0);
    for (int n = 0; n < 40; n++) begin
      logic [1:0] fm, lw;
      fm = 2'($urandom);
      lw = 2'($urandom);
      frame(fm, lw, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
            (fm == 2'd1) ? 16 : 32, ($urandom % 4) == 0);
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule